// File: doc/BRIEF.md
# Two-Way Latched Bus Transceiver

This block moves a data word between two buses, side A and side B, through two independent banks of storage latches, one for each direction. The forward bank picks up words from side A and presents them on side B. The return bank picks up words from side B and presents them on side A. Each direction has three active-low controls:

- a select, which gates both loading and driving;
- an open control, which makes the bank transparent while it is low;
- a drive control, which turns on that direction's output.

Pads are not modelled as tri-state wires. Each side has an input vector, an output vector and an output-enable flag. A deasserted flag stands for high impedance, so a pad wrapper can resolve the flags onto bidirectional pins.

Transparency is combinational. While a bank is open, its output follows the incoming word in the same cycle. On each rising clock edge during which the bank is open, the incoming word is also written into the bank's storage. When the open control returns high, the bank keeps presenting the last word stored before that change.

Every pin is a plain level signal, sampled or decoded continuously. There is no handshake and no back-pressure. An upstream agent that wants a word captured must keep it stable across at least one rising clock edge while the bank is open.

An asynchronous active-low reset clears both banks to zero and disables both outputs for as long as it is held.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: While reset is asserted, both output enables are low. After reset, both banks hold zero, so a direction that drives without opening presents 0.
- R2: With select low and open low, the bank is transparent. When the direction also drives, its output equals the current incoming word in the same cycle.
- R3: With select low and open high, the bank holds the word it stored at the last rising clock edge at which it was open, whatever the incoming word now is.
- R4: With select high, the bank keeps its stored word whatever the open control does, and that direction's output enable is low.
- R5: With drive high, that direction's output enable is low, while the bank still loads when select and open are low.
- R6: A direction's output enable is high exactly when both its select and its drive are low. The word then driven is the bank's current output: the incoming word if open, otherwise the stored word.
- R7: While a direction's output enable is low, its output vector reads all zeros.
- R8: The return direction behaves the same way with its own three controls, and neither direction's controls affect the other's bank or output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; banks store on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_in | input | DATA_W | Word arriving from side A |
| a_out | output | DATA_W | Word driven onto side A by the return direction |
| a_oe | output | 1 | Side A output enable; low means high impedance |
| b_in | input | DATA_W | Word arriving from side B |
| b_out | output | DATA_W | Word driven onto side B by the forward direction |
| b_oe | output | 1 | Side B output enable; low means high impedance |
| ab_sel_n | input | 1 | Forward select, active low |
| ab_open_n | input | 1 | Forward bank transparent when low |
| ab_drv_n | input | 1 | Forward output drive, active low |
| ba_sel_n | input | 1 | Return select, active low |
| ba_open_n | input | 1 | Return bank transparent when low |
| ba_drv_n | input | 1 | Return output drive, active low |

## Verification
The bench walks through all 64 combinations of the six control pins. Each combination is held for two steps, and the words on both sides are each other's complement in those two steps. A transparent bank therefore shows a fresh value, while a holding bank shows a value left over from an earlier combination, which separates R2 from R3 and R4.

Because both directions are varied together, any coupling between them shows up as a wrong value on the quiet side (R8). Directed sequences check three things:
- the cleared banks after reset (R1);
- storage that continues with drive off, then shows up once drive turns on (R5);
- a select-high interval that must leave the stored word untouched even while open is low (R4).

// File: rtl/xcvr_pkg.sv
`timescale 1ns/1ps
package xcvr_pkg;
  localparam int NUM_DIRS = 2;
  localparam int DIR_AB   = 0;
  localparam int DIR_BA   = 1;

  typedef struct packed {
    logic sel_n;
    logic open_n;
    logic drv_n;
  } dir_ctrl_t;

  typedef struct packed {
    logic load;
    logic drive;
  } dir_act_t;
endpackage

// File: rtl/xcvr_ctrl_decode.sv
`timescale 1ns/1ps
module xcvr_ctrl_decode
  import xcvr_pkg::*;
(
  input  logic      rst_n,
  input  dir_ctrl_t ctrl,
  output dir_act_t  act
);
  always_comb begin
    act.load  = rst_n && !ctrl.sel_n && !ctrl.open_n;
    act.drive = rst_n && !ctrl.sel_n && !ctrl.drv_n;
  end
endmodule

// File: rtl/xcvr_latch_bank.sv
`timescale 1ns/1ps
module xcvr_latch_bank #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              open_n,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);
  logic [DATA_W-1:0] store_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    store_q <= '0;
    else if (load) store_q <= din;
  end

  assign q = load ? din : store_q;

  a_r4_keep_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    sel_n |=> $stable(store_q));

  a_r3_keep_when_closed: assert property (@(posedge clk) disable iff (!rst_n)
    open_n |=> $stable(store_q));

  a_r2_capture_when_open: assert property (@(posedge clk) disable iff (!rst_n)
    (!sel_n && !open_n) |=> (store_q == $past(din)));
endmodule

// File: rtl/xcvr_out_gate.sv
`timescale 1ns/1ps
module xcvr_out_gate #(
  parameter int DATA_W = 8
) (
  input  logic              drive,
  input  logic [DATA_W-1:0] q,
  output logic [DATA_W-1:0] out,
  output logic              oe
);
  assign oe  = drive;
  assign out = drive ? q : '0;
endmodule

// File: rtl/bidir_latch_xcvr.sv
`timescale 1ns/1ps
module bidir_latch_xcvr
  import xcvr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              ab_sel_n,
  input  logic              ab_open_n,
  input  logic              ab_drv_n,
  input  logic              ba_sel_n,
  input  logic              ba_open_n,
  input  logic              ba_drv_n
);
  dir_ctrl_t         ctrl_v [NUM_DIRS];
  dir_act_t          act_v  [NUM_DIRS];
  logic [DATA_W-1:0] din_v  [NUM_DIRS];
  logic [DATA_W-1:0] q_v    [NUM_DIRS];
  logic [DATA_W-1:0] out_v  [NUM_DIRS];
  logic              oe_v   [NUM_DIRS];

  assign ctrl_v[DIR_AB] = dir_ctrl_t'({ab_sel_n, ab_open_n, ab_drv_n});
  assign ctrl_v[DIR_BA] = dir_ctrl_t'({ba_sel_n, ba_open_n, ba_drv_n});
  assign din_v[DIR_AB]  = a_in;
  assign din_v[DIR_BA]  = b_in;

  for (genvar d = 0; d < NUM_DIRS; d++) begin : g_dir
    xcvr_ctrl_decode u_dec (
      .rst_n (rst_n),
      .ctrl  (ctrl_v[d]),
      .act   (act_v[d])
    );

    xcvr_latch_bank #(.DATA_W(DATA_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_n  (ctrl_v[d].sel_n),
      .open_n (ctrl_v[d].open_n),
      .load   (act_v[d].load),
      .din    (din_v[d]),
      .q      (q_v[d])
    );

    xcvr_out_gate #(.DATA_W(DATA_W)) u_gate (
      .drive (act_v[d].drive),
      .q     (q_v[d]),
      .out   (out_v[d]),
      .oe    (oe_v[d])
    );
  end

  assign b_out = out_v[DIR_AB];
  assign b_oe  = oe_v[DIR_AB];
  assign a_out = out_v[DIR_BA];
  assign a_oe  = oe_v[DIR_BA];

  always_comb begin
    if (!rst_n) begin
      a_r1_quiet_in_reset: assert (!a_oe && !b_oe);
    end
  end

  a_r7_b_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !b_oe |-> (b_out == '0));

  a_r7_a_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !a_oe |-> (a_out == '0));

  a_r2_b_follows_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_sel_n && !ab_open_n && !ab_drv_n) |-> (b_out == a_in));

  a_r8_a_follows_b: assert property (@(posedge clk) disable iff (!rst_n)
    (!ba_sel_n && !ba_open_n && !ba_drv_n) |-> (a_out == b_in));

  a_r6_b_off_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    ab_sel_n |-> !b_oe);
endmodule

// File: tb/test_bidir_latch_xcvr.sv
`timescale 1ns/1ps
module test_bidir_latch_xcvr;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] a_in, b_in;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;
  logic         ab_sel_n, ab_open_n, ab_drv_n;
  logic         ba_sel_n, ba_open_n, ba_drv_n;

  int checks   = 0;
  int failures = 0;
  int contend  = 0;
  logic [W-1:0] m_ab, m_ba;

  always #2 clk = ~clk;

  bidir_latch_xcvr #(.DATA_W(W)) i_bidir_latch_xcvr (
    .clk(clk), .rst_n(rst_n),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .ab_sel_n(ab_sel_n), .ab_open_n(ab_open_n), .ab_drv_n(ab_drv_n),
    .ba_sel_n(ba_sel_n), .ba_open_n(ba_open_n), .ba_drv_n(ba_drv_n)
  );

  task automatic chk(input bit ok, input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one direction: ctl = {sel_n, open_n, drv_n}
  task automatic check_dir(input logic [2:0] ctl, input logic [W-1:0] din, inout logic [W-1:0] model,
                           input logic [W-1:0] out, input logic oe, input string pre);
    logic load, drive;
    logic [W-1:0] q, exp;
    string toe, tout;
    load  = !ctl[2] && !ctl[1];
    drive = !ctl[2] && !ctl[0];
    q     = load ? din : model;
    exp   = drive ? q : '0;
    toe   = drive ? "R6" : (ctl[2] ? "R4" : "R5");
    tout  = !drive ? "R7" : (load ? "R2" : "R3");
    chk(oe == drive, {pre, toe, " oe"}, W'(oe), W'(drive));
    chk(out == exp, {pre, tout, " data"}, out, exp);
    if (load) model = din;
  endtask

  task automatic step(input logic [2:0] abc, input logic [2:0] bac, input logic [W-1:0] av, input logic [W-1:0] bv);
    @(negedge clk);
    {ab_sel_n, ab_open_n, ab_drv_n} = abc;
    {ba_sel_n, ba_open_n, ba_drv_n} = bac;
    a_in = av;
    b_in = bv;
    #1;
    if (a_oe && b_oe) contend++;
    check_dir(abc, av, m_ab, b_out, b_oe, "");
    check_dir(bac, bv, m_ba, a_out, a_oe, "R8 ");
  endtask

  initial begin
    #(4 * 20000);
    failures++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    a_in = 8'h5A; b_in = 8'hA5;
    {ab_sel_n, ab_open_n, ab_drv_n} = 3'b000;
    {ba_sel_n, ba_open_n, ba_drv_n} = 3'b000;
    m_ab = '0; m_ba = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: outputs stay off during reset even with every control active
    chk(!b_oe, "R1 b_oe in reset", W'(b_oe), '0);
    chk(!a_oe, "R1 a_oe in reset", W'(a_oe), '0);
    chk(b_out == '0, "R1 b_out in reset", b_out, '0);
    chk(a_out == '0, "R1 a_out in reset", a_out, '0);
    {ab_sel_n, ab_open_n, ab_drv_n} = 3'b011;
    {ba_sel_n, ba_open_n, ba_drv_n} = 3'b011;
    #1 rst_n = 1'b1;
    @(posedge clk);
    @(negedge clk);
    // R1: banks cleared; drive without opening shows zero
    {ab_drv_n, ba_drv_n} = 2'b00;
    #1;
    chk(b_oe && b_out == '0, "R1 b bank cleared", b_out, '0);
    chk(a_oe && a_out == '0, "R1 a bank cleared", a_out, '0);

    // exhaustive control sweep
    for (int c = 0; c < 64; c++) begin
      logic [W-1:0] av, bv;
      av = W'(c * 29 + 7);
      bv = W'(c * 53 + 3);
      step(c[2:0], c[5:3], av, bv);
      step(c[2:0], c[5:3], ~av, ~bv);
    end

    // R5: storage continues with drive off, appears when drive turns on
    step(3'b001, 3'b111, 8'hC3, 8'h00);
    step(3'b010, 3'b111, 8'h11, 8'h00);
    chk(b_out == 8'hC3, "R5 stored while undriven", b_out, 8'hC3);

    // R4: select high freezes the bank even with open low
    step(3'b000, 3'b111, 8'h96, 8'h00);
    step(3'b101, 3'b111, 8'h3C, 8'h00);
    step(3'b100, 3'b111, 8'h77, 8'h00);
    step(3'b010, 3'b111, 8'hE1, 8'h00);
    chk(b_out == 8'h96, "R4 deselected keep", b_out, 8'h96);

    // R8: return direction loads while forward direction is frozen
    step(3'b110, 3'b000, 8'h00, 8'h4B);
    step(3'b010, 3'b010, 8'h00, 8'hB4);
    chk(a_out == 8'h4B, "R8 return hold", a_out, 8'h4B);
    chk(b_out == 8'h96, "R8 forward untouched", b_out, 8'h96);

    $display("info: cycles with both sides driving = %0d", contend);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule